// File: doc/BRIEF.md
# Core Power-Down and Wake-Up Sequencer

This block controls the power-down sequence of a small 8-bit processor core. The decoder sends a one-cycle strobe when it executes the power-down instruction. If no enabled interrupt is pending at that moment, the block does the following:
- it gates the oscillator;
- it sends one clear pulse to the watchdog, which keeps counting;
- it clears the power-down status bit;
- it sets the time-out status bit.

If an enabled interrupt is already pending, the instruction has no effect.

While the core is gated, three things can end the sleep:
- an enabled interrupt from a source that can run without the core clock;
- a watchdog time-out;
- the external reset input.

An interrupt or watchdog wake turns the oscillator back on. On the next edge the block leaves sleep and sends one resume pulse to the fetch unit, which then executes the instruction after the power-down instruction. If the global interrupt enable was set at the wake edge and an interrupt caused the wake, a vector-branch request follows one cycle after the resume pulse. The global enable never decides whether the core wakes. The external reset returns the core to run state with no resume and no branch, and the status bits keep the values that the sleep left.

Top module: `slp_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low): `osc_en_o`=1, `pd_o`=1, `to_o`=1, and `wdt_clr_o`, `resume_o`, `vector_o` are 0. `pd_o` is never set again after reset.
- R2: A `sleep_i` strobe in run state with no enabled pending flag (`irq_flag_i & irq_en_i` all zero) gives, after that edge, `osc_en_o`=0, `pd_o`=0, `to_o`=1 and `wdt_clr_o`=1 for exactly one cycle.
- R3: A `sleep_i` strobe in run state while any source has both its flag and its enable set is a no-op: `osc_en_o` stays 1, there is no `wdt_clr_o` pulse, and `pd_o` and `to_o` are unchanged.
- R4: A flag whose enable bit is 0 neither blocks power-down nor wakes the core.
- R5: While asleep, an enabled flag on an asynchronous-capable source raises `osc_en_o` after that edge. `resume_o` is then high for exactly one cycle, on the cycle after that. `to_o` is unchanged and `gie_i` has no effect on waking.
- R6: Sources whose bit in `ASYNC_MASK` is 0 are ignored while asleep (default `ASYNC_MASK`=4'b0101, i.e. sources 0 and 2 are asynchronous-capable).
- R7: After an interrupt wake with `gie_i`=1 at the wake edge, `vector_o` is high for one cycle, the cycle after the `resume_o` pulse. With `gie_i`=0, `vector_o` stays 0.
- R8: A `wdt_timeout_i` pulse while asleep wakes the core like R5, clears `to_o`, and gives no `vector_o`.
- R9: `ext_rst_i` while asleep sets `osc_en_o`=1 after that edge. It gives no `resume_o` and no `vector_o`, and leaves `pd_o` and `to_o` unchanged.
- R10: `sleep_i` while asleep and `wdt_timeout_i` while running have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-on reset |
| sleep_i | input | 1 | Decoded power-down instruction strobe |
| ext_rst_i | input | 1 | External reset request |
| wdt_timeout_i | input | 1 | Watchdog time-out pulse |
| irq_flag_i | input | N | Interrupt flags, one per source |
| irq_en_i | input | N | Individual interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| osc_en_o | output | 1 | Oscillator drive enable |
| wdt_clr_o | output | 1 | Watchdog and postscaler clear pulse |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Time-out status bit |
| resume_o | output | 1 | One-cycle resume request to fetch |
| vector_o | output | 1 | One-cycle branch-to-vector request |

## Verification
A stimulus applied before an edge changes `osc_en_o`, `wdt_clr_o`, `pd_o` and `to_o` right after that edge. `resume_o` follows one edge after the oscillator returns, and `vector_o` one edge after that. The driver applies one stimulus per cycle and queues the output values expected after that edge. The monitor compares them shortly after the edge, so each comparison falls in the exact cycle in which a result is due. The test covers three timing cases: a flag already pending at the strobe, a flag arriving while asleep, and a watchdog wake.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } slp_state_e;

    typedef struct packed {
        slp_state_e state;
        logic       osc_en;
        logic       wdt_clr;
        logic       pd;
        logic       to;
        logic       branch;
    } slp_regs_t;
endpackage

// File: rtl/slp_wake_detect.sv
module slp_wake_detect #(
    parameter int          N          = 4,
    parameter logic [N-1:0] ASYNC_MASK = 4'b0101
) (
    input  logic [N-1:0] irq_flag_i,
    input  logic [N-1:0] irq_en_i,
    output logic         pend_any_o,
    output logic         wake_irq_o
);
    logic [N-1:0] run_hit;
    logic [N-1:0] slp_hit;

    for (genvar i = 0; i < N; i++) begin : g_src
        assign run_hit[i] = irq_flag_i[i] & irq_en_i[i];
        if (ASYNC_MASK[i]) begin : g_async
            assign slp_hit[i] = run_hit[i];
        end else begin : g_sync
            assign slp_hit[i] = 1'b0;
        end
    end

    assign pend_any_o = |run_hit;
    assign wake_irq_o = |slp_hit;
endmodule

// File: rtl/slp_resume_seq.sv
module slp_resume_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic branch_i,
    input  logic kill_i,
    output logic resume_o,
    output logic vector_o
);
    logic resume_d, resume_q;
    logic vector_d, vector_q;

    always_comb begin
        resume_d = go_i & ~kill_i;
        vector_d = resume_q & branch_i & ~kill_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resume_q <= 1'b0;
            vector_q <= 1'b0;
        end else begin
            resume_q <= resume_d;
            vector_q <= vector_d;
        end
    end

    assign resume_o = resume_q;
    assign vector_o = vector_q;
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int           N          = 4,
    parameter logic [N-1:0] ASYNC_MASK = 4'b0101
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep_i,
    input  logic         ext_rst_i,
    input  logic         wdt_timeout_i,
    input  logic [N-1:0] irq_flag_i,
    input  logic [N-1:0] irq_en_i,
    input  logic         gie_i,
    output logic         osc_en_o,
    output logic         wdt_clr_o,
    output logic         pd_o,
    output logic         to_o,
    output logic         resume_o,
    output logic         vector_o
);
    slp_regs_t r_d, r_q;
    logic      pend_any;
    logic      wake_irq;
    logic      go;

    slp_wake_detect #(.N(N), .ASYNC_MASK(ASYNC_MASK)) u_detect (
        .irq_flag_i (irq_flag_i),
        .irq_en_i   (irq_en_i),
        .pend_any_o (pend_any),
        .wake_irq_o (wake_irq)
    );

    always_comb begin
        r_d         = r_q;
        r_d.wdt_clr = 1'b0;
        go          = 1'b0;
        if (ext_rst_i) begin
            r_d.state  = ST_RUN;
            r_d.osc_en = 1'b1;
        end else begin
            case (r_q.state)
                ST_RUN: begin
                    if (sleep_i && !pend_any) begin
                        r_d.state   = ST_SLEEP;
                        r_d.osc_en  = 1'b0;
                        r_d.wdt_clr = 1'b1;
                        r_d.pd      = 1'b0;
                        r_d.to      = 1'b1;
                    end
                end
                ST_SLEEP: begin
                    if (wake_irq || wdt_timeout_i) begin
                        r_d.state  = ST_WAKE;
                        r_d.osc_en = 1'b1;
                        r_d.branch = wake_irq & gie_i;
                        if (wdt_timeout_i) begin
                            r_d.to = 1'b0;
                        end
                    end
                end
                ST_WAKE: begin
                    r_d.state = ST_RUN;
                    go        = 1'b1;
                end
                default: begin
                    r_d.state = ST_RUN;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_RUN, osc_en: 1'b1, wdt_clr: 1'b0,
                     pd: 1'b1, to: 1'b1, branch: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    slp_resume_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go),
        .branch_i (r_q.branch),
        .kill_i   (ext_rst_i),
        .resume_o (resume_o),
        .vector_o (vector_o)
    );

    assign osc_en_o  = r_q.osc_en;
    assign wdt_clr_o = r_q.wdt_clr;
    assign pd_o      = r_q.pd;
    assign to_o      = r_q.to;
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk
    import slp_pkg::*;
#(
    parameter int           N          = 4,
    parameter logic [N-1:0] ASYNC_MASK = 4'b0101
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sleep_i,
    input logic         ext_rst_i,
    input logic         wdt_timeout_i,
    input logic [N-1:0] irq_flag_i,
    input logic [N-1:0] irq_en_i,
    input logic         osc_en_o,
    input logic         wdt_clr_o,
    input logic         pd_o,
    input logic         to_o,
    input logic         resume_o,
    input logic         vector_o,
    input slp_state_e   st
);
    assert_pd_never_rises_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_o |=> !pd_o);

    assert_gate_with_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en_o) |-> (wdt_clr_o && !pd_o && to_o));

    assert_clear_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_o |=> !wdt_clr_o);

    assert_pending_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && sleep_i && !ext_rst_i && (|(irq_flag_i & irq_en_i)))
        |=> (osc_en_o && !wdt_clr_o && $stable(pd_o) && $stable(to_o)));

    assert_resume_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |=> !resume_o);

    assert_sync_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP && !ext_rst_i && !wdt_timeout_i
         && !(|(irq_flag_i & irq_en_i & ASYNC_MASK))) |=> !osc_en_o);

    assert_vector_after_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vector_o |-> ($past(resume_o) && !resume_o));

    assert_ext_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_i |=> (osc_en_o && !resume_o && !vector_o));
endmodule

bind slp_ctrl slp_ctrl_chk #(.N(N), .ASYNC_MASK(ASYNC_MASK)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_i       (sleep_i),
    .ext_rst_i     (ext_rst_i),
    .wdt_timeout_i (wdt_timeout_i),
    .irq_flag_i    (irq_flag_i),
    .irq_en_i      (irq_en_i),
    .osc_en_o      (osc_en_o),
    .wdt_clr_o     (wdt_clr_o),
    .pd_o          (pd_o),
    .to_o          (to_o),
    .resume_o      (resume_o),
    .vector_o      (vector_o),
    .st            (r_q.state)
);

// File: tb/test_slp_ctrl.sv
`timescale 1ns/100ps
module test_slp_ctrl;
    localparam int N = 4;

    typedef struct {
        string      tag;
        logic [5:0] exp;  // {osc, clr, pd, to, resume, vector}
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sleep_i = 1'b0;
    logic         ext_rst_i = 1'b0;
    logic         wdt_timeout_i = 1'b0;
    logic [N-1:0] irq_flag_i = '0;
    logic [N-1:0] irq_en_i = '0;
    logic         gie_i = 1'b0;
    logic         osc_en_o, wdt_clr_o, pd_o, to_o, resume_o, vector_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    slp_ctrl #(.N(N), .ASYNC_MASK(4'b0101)) i_slp_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .ext_rst_i(ext_rst_i),
        .wdt_timeout_i(wdt_timeout_i), .irq_flag_i(irq_flag_i),
        .irq_en_i(irq_en_i), .gie_i(gie_i), .osc_en_o(osc_en_o),
        .wdt_clr_o(wdt_clr_o), .pd_o(pd_o), .to_o(to_o),
        .resume_o(resume_o), .vector_o(vector_o)
    );

    // monitor: compares one queued expectation just after each edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            logic [5:0] act;
            it  = sb.pop_front();
            act = {osc_en_o, wdt_clr_o, pd_o, to_o, resume_o, vector_o};
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s: got osc/clr/pd/to/res/vec=%b expected %b",
                         it.tag, act, it.exp);
            end
        end
    end

    // driver: apply inputs for one edge and queue the outputs due after it
    task automatic step(input logic slp, input logic xr, input logic wdt,
                        input logic [N-1:0] fl, input logic [N-1:0] en,
                        input logic g, input logic [5:0] exp, input string tag);
        sleep_i = slp; ext_rst_i = xr; wdt_timeout_i = wdt;
        irq_flag_i = fl; irq_en_i = en; gie_i = g;
        sb.push_back('{tag: tag, exp: exp});
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0,0,0,4'b0000,4'b0000,0, 6'b101100, "R1 reset state");
        // R3 flag already pending: sleep is a no-op
        step(1,0,0,4'b0001,4'b0001,0, 6'b101100, "R3 pending before sleep");
        step(0,0,0,4'b0000,4'b0000,0, 6'b101100, "R3 no late effect");
        // R10 watchdog time-out while running has no effect
        step(0,0,1,4'b0000,4'b0000,0, 6'b101100, "R10 wdt while running");
        // R4 disabled flag does not block sleep; R2 entry
        step(1,0,0,4'b0010,4'b0001,0, 6'b010100, "R2 R4 sleep entry");
        step(0,0,0,4'b0000,4'b0000,0, 6'b000100, "R2 clear is one cycle");
        // R6 sync-only source ignored while asleep
        step(0,0,0,4'b0010,4'b0010,1, 6'b000100, "R6 sync source ignored");
        // R4 disabled async flag ignored while asleep
        step(0,0,0,4'b0100,4'b0000,1, 6'b000100, "R4 disabled flag ignored");
        // R10 sleep strobe while asleep ignored
        step(1,0,0,4'b0000,4'b0000,0, 6'b000100, "R10 sleep while asleep");
        // R5 async flag arrives during sleep, gie=0
        step(0,0,0,4'b0100,4'b0100,0, 6'b100100, "R5 wake osc on");
        step(0,0,0,4'b0000,4'b0000,0, 6'b100110, "R5 resume pulse");
        step(0,0,0,4'b0000,4'b0000,0, 6'b100100, "R7 no vector gie=0");
        // R7 wake with gie=1
        step(1,0,0,4'b0000,4'b0000,0, 6'b010100, "R2 second entry");
        step(0,0,0,4'b0001,4'b0001,1, 6'b100100, "R5 wake gie=1");
        step(0,0,0,4'b0000,4'b0000,0, 6'b100110, "R5 resume gie=1");
        step(0,0,0,4'b0000,4'b0000,0, 6'b100101, "R7 vector after resume");
        step(0,0,0,4'b0000,4'b0000,0, 6'b100100, "R7 vector one cycle");
        // R8 watchdog wake
        step(1,0,0,4'b0000,4'b0000,1, 6'b010100, "R2 entry before wdt");
        step(0,0,1,4'b0000,4'b0000,1, 6'b100000, "R8 wdt wake clears to");
        step(0,0,0,4'b0000,4'b0000,1, 6'b100010, "R8 resume after wdt");
        step(0,0,0,4'b0000,4'b0000,1, 6'b100000, "R8 no vector");
        // R9 external reset while asleep
        step(1,0,0,4'b0000,4'b0000,1, 6'b010100, "R2 entry sets to again");
        step(0,1,0,4'b0000,4'b0000,1, 6'b100100, "R9 ext reset osc on");
        step(0,0,0,4'b0000,4'b0000,1, 6'b100100, "R9 no resume no vector");
        step(0,0,0,4'b0000,4'b0000,1, 6'b100100, "R9 stays quiet");
        step(1,0,0,4'b0000,4'b0000,0, 6'b010100, "R9 run state after reset");
        @(posedge clk); #2;
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 2000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule